// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Generator

This block drives three pulse-width-modulated channels from a single symmetric timebase. An internal signed timer climbs from minus half the programmed period up to plus half, then falls back again. Each channel compares the magnitude of the timer against its own duty value, so every pulse is centred on a timer zero crossing and is symmetric about it. A one-cycle sync pulse marks the start of every period.

Software-side writes go into pending registers for the period, the three duties and an update-mode bit. The values the timebase actually uses are copied from the pending registers only at reload boundaries. In single-update mode that happens at period start. In double-update mode it also happens at mid period. A new period value therefore takes effect from the next boundary, with no mixed-length half period in between. Clearing the timer enable for at least one clock and then setting it again aborts the running period and starts a fresh one at once from the pending values, which produces an extra sync pulse.

Register map on the write port:
- address 0: period TM
- addresses 1, 2, 3: duties of channels A, B and C
- address 4: control, bit 0 selects double update

The half count is H = max(TM/2, 1), using integer division. One full period lasts 4*H clock cycles: 2*H cycles on the rising leg and 2*H cycles on the falling leg.

Top module: `pwm_center3`

## Requirements
- R1: After reset, `pwm_out` and `sync_out` are low, the pending period is 8, all pending duties are 0 and single-update mode is selected.
- R2: While running, the timer stays within -H..+H. `sync_out` pulses high for exactly one cycle once per period, so consecutive pulses are 4*H cycles apart.
- R3: A channel output is high while |timer| < duty. Per period a channel is high for 2*(2*D-1) cycles when 1 <= D <= H, never when D = 0, and in every cycle when D > H.
- R4: With control bit 0 = 0, writes to period or duty registers change nothing in the period in progress and apply from the next period start.
- R5: With control bit 0 = 1, pending values are also loaded at mid period. A period write made in the first half gives that period a length of 2*H_old + 2*H_new cycles.
- R6: After a period write, the first half period after the reload boundary already has the new length 2*H_new, and all later periods last 4*H_new.
- R7: Holding `en_tmr` low for a cycle and raising it again aborts the period. A new period starts from the pending values and `sync_out` pulses on the second clock edge after `en_tmr` is sampled high.
- R8: While `en_out` is low, all channel outputs are low and the timer and sync pulses keep running.
- R9: While `en_tmr` is low, the timer is stopped and both `pwm_out` and `sync_out` are low.
- R10: A programmed period below 2 is treated as H = 1, which gives a 4-cycle period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 period, 1..3 duties, 4 control) |
| wr_data | input | 12 | Register write data |
| en_tmr | input | 1 | Timer enable; a low-to-high transition restarts the period |
| en_out | input | 1 | Channel output enable |
| pwm_out | output | 3 | Channel outputs, bit 0 = A |
| sync_out | output | 1 | One-cycle period-start pulse |

## Verification
The bench targets four corner cases.

- A period rewrite mid-period. A design that reloaded immediately would give a sync gap that is neither the old nor the new length. A design that reloaded one half late would give a 2*H_old + 2*H_new gap in single-update mode.
- A duty change in double-update mode. It must split the pulse width between the two legs; a design that ignored the mid-period reload would keep the old width for the whole period.
- An enable toggle. It must produce a sync exactly two edges later; a design that lacked the restart would simply resume the old ramp.
- Zero and oversized duties and a period of 1. These probe the compare boundary and the half-count clamp, where an off-by-one shows up as a wrong high-cycle count or a stalled timer.

// File: rtl/pwm_center3_pkg.sv
package pwm_center3_pkg;

  typedef enum logic {
    LEG_UP   = 1'b0,
    LEG_DOWN = 1'b1
  } leg_e;

  typedef enum logic [2:0] {
    RA_PERIOD = 3'd0,
    RA_DUTY0  = 3'd1,
    RA_CTRL   = 3'd4
  } reg_addr_e;

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs #(
  parameter int W       = 12,
  parameter int NCH     = 3,
  parameter int AW      = 3,
  parameter int RST_TM  = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_addr,
  input  logic [W-1:0]            wr_data,
  output logic [W-1:0]            p_tm,
  output logic [NCH-1:0][W-1:0]   p_duty,
  output logic                    p_dbl
);
  import pwm_center3_pkg::*;

  localparam logic [AW-1:0] A_PER  = AW'(RA_PERIOD);
  localparam logic [AW-1:0] A_CTRL = AW'(RA_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      p_tm  <= W'(RST_TM);
      p_dbl <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == A_PER)  p_tm  <= wr_data;
      if (wr_addr == A_CTRL) p_dbl <= wr_data[0];
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_duty
    localparam logic [AW-1:0] A_D = AW'(int'(RA_DUTY0) + k);
    always_ff @(posedge clk) begin
      if (rst)                          p_duty[k] <= '0;
      else if (wr_en && wr_addr == A_D) p_duty[k] <= wr_data;
    end
  end

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int W   = 12,
  parameter int NCH = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en_tmr,
  input  logic [W-1:0]             p_tm,
  input  logic [NCH-1:0][W-1:0]    p_duty,
  input  logic                     p_dbl,
  output logic                     run,
  output logic signed [W:0]        tmr,
  output logic [W-1:0]             h_act,
  output logic [NCH-1:0][W-1:0]    d_act,
  output logic                     at_start
);
  import pwm_center3_pkg::*;

  localparam int TW = W + 1;

  leg_e                  leg;
  logic [W-1:0]          h_new;
  logic signed [TW-1:0]  h_new_s;
  logic signed [TW-1:0]  h_cur_s;
  logic                  up_turn;
  logic                  dn_turn;

  always_comb begin
    h_new   = (p_tm[W-1:1] == '0) ? W'(1) : {1'b0, p_tm[W-1:1]};
    h_new_s = $signed({1'b0, h_new});
    h_cur_s = $signed({1'b0, h_act});
    up_turn = (tmr == h_cur_s - TW'(1));
    dn_turn = (tmr == -h_cur_s + TW'(1));
    at_start = run && (leg == LEG_UP) && (tmr == -h_cur_s);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run   <= 1'b0;
      tmr   <= '0;
      leg   <= LEG_UP;
      h_act <= W'(1);
      d_act <= '0;
    end else if (!en_tmr) begin
      run <= 1'b0;
    end else if (!run) begin
      run   <= 1'b1;
      h_act <= h_new;
      d_act <= p_duty;
      tmr   <= -h_new_s;
      leg   <= LEG_UP;
    end else if (leg == LEG_UP) begin
      if (up_turn) begin
        leg <= LEG_DOWN;
        if (p_dbl) begin
          h_act <= h_new;
          d_act <= p_duty;
          tmr   <= h_new_s;
        end else begin
          tmr   <= h_cur_s;
        end
      end else begin
        tmr <= tmr + TW'(1);
      end
    end else begin
      if (dn_turn) begin
        leg   <= LEG_UP;
        h_act <= h_new;
        d_act <= p_duty;
        tmr   <= -h_new_s;
      end else begin
        tmr <= tmr - TW'(1);
      end
    end
  end

endmodule

// File: rtl/pwm_outstage.sv
module pwm_outstage #(
  parameter int W   = 12,
  parameter int NCH = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    run,
  input  logic                    en_out,
  input  logic signed [W:0]       tmr,
  input  logic [NCH-1:0][W-1:0]   d_act,
  input  logic                    at_start,
  output logic [NCH-1:0]          pwm_out,
  output logic                    sync_out
);
  localparam int TW = W + 1;

  logic [TW-1:0] mag;

  always_comb begin
    mag = tmr[TW-1] ? TW'(-tmr) : TW'(tmr);
  end

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) pwm_out[k] <= 1'b0;
      else     pwm_out[k] <= run && en_out && (mag < {1'b0, d_act[k]});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sync_out <= 1'b0;
    else     sync_out <= at_start;
  end

endmodule

// File: rtl/pwm_center3.sv
module pwm_center3 #(
  parameter int W      = 12,
  parameter int NCH    = 3,
  parameter int AW     = 3,
  parameter int RST_TM = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_addr,
  input  logic [W-1:0]    wr_data,
  input  logic            en_tmr,
  input  logic            en_out,
  output logic [NCH-1:0]  pwm_out,
  output logic            sync_out
);
  logic [W-1:0]            p_tm;
  logic [NCH-1:0][W-1:0]   p_duty;
  logic                    p_dbl;
  logic                    run_w;
  logic signed [W:0]       tmr_w;
  logic [W-1:0]            h_act_w;
  logic [NCH-1:0][W-1:0]   d_act_w;
  logic                    at_start_w;

  pwm_regs #(.W(W), .NCH(NCH), .AW(AW), .RST_TM(RST_TM)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .p_tm(p_tm), .p_duty(p_duty), .p_dbl(p_dbl)
  );

  pwm_timebase #(.W(W), .NCH(NCH)) u_tb (
    .clk(clk), .rst(rst), .en_tmr(en_tmr), .p_tm(p_tm), .p_duty(p_duty),
    .p_dbl(p_dbl), .run(run_w), .tmr(tmr_w), .h_act(h_act_w),
    .d_act(d_act_w), .at_start(at_start_w)
  );

  pwm_outstage #(.W(W), .NCH(NCH)) u_out (
    .clk(clk), .rst(rst), .run(run_w), .en_out(en_out), .tmr(tmr_w),
    .d_act(d_act_w), .at_start(at_start_w), .pwm_out(pwm_out),
    .sync_out(sync_out)
  );

endmodule

// File: rtl/pwm_center3_chk.sv
module pwm_center3_chk #(
  parameter int W   = 12,
  parameter int NCH = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              en_out,
  input logic [NCH-1:0]    pwm_out,
  input logic              sync_out,
  input logic              run,
  input logic signed [W:0] tmr,
  input logic [W-1:0]      h_act
);

  AST_TMR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    run |-> (tmr <= $signed({1'b0, h_act})) && (tmr >= -$signed({1'b0, h_act})));  // R2

  AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (rst)
    sync_out |=> !sync_out);  // R2

  AST_RESTART_SYNC: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |=> sync_out);  // R7

  AST_GATED_LOW: assert property (@(posedge clk) disable iff (rst)
    !en_out |=> (pwm_out == '0));  // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !run |=> (pwm_out == '0) && !sync_out);  // R9

endmodule

bind pwm_center3 pwm_center3_chk #(.W(W), .NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .en_out(en_out), .pwm_out(pwm_out),
  .sync_out(sync_out), .run(run_w), .tmr(tmr_w), .h_act(h_act_w)
);

// File: tb/sim_pwm_center3.sv
module sim_pwm_center3;
  localparam int W = 12;
  localparam int NCH = 3;
  localparam int AW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic en_tmr = 1'b0;
  logic en_out = 1'b0;
  logic [NCH-1:0] pwm_out;
  logic sync_out;

  int vectors = 0;
  int miscompares = 0;
  bit cmp_on = 1'b0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  pwm_center3 #(.W(W), .NCH(NCH), .AW(AW), .RST_TM(8)) u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .en_tmr(en_tmr), .en_out(en_out), .pwm_out(pwm_out), .sync_out(sync_out)
  );

  // Requirement-level model of the expected waveform
  int m_ptm, m_dbl, m_run, m_t, m_up, m_h;
  int m_pd [NCH];
  int m_d  [NCH];
  logic [NCH-1:0] e_out;
  logic e_sync;

  function automatic int half_of(int tm);
    return (tm / 2 < 1) ? 1 : tm / 2;
  endfunction

  function automatic int absv(int v);
    return (v < 0) ? -v : v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ptm <= 8; m_dbl <= 0; m_run <= 0; m_t <= 0; m_up <= 1; m_h <= 1;
      for (int k = 0; k < NCH; k++) begin m_pd[k] <= 0; m_d[k] <= 0; end
      e_out <= '0; e_sync <= 1'b0;
    end else begin
      if (wr_en) begin
        if (wr_addr == 0) m_ptm <= int'(wr_data);
        if (wr_addr == 4) m_dbl <= int'(wr_data[0]);
        for (int k = 0; k < NCH; k++) if (int'(wr_addr) == k + 1) m_pd[k] <= int'(wr_data);
      end
      for (int k = 0; k < NCH; k++)
        e_out[k] <= (m_run != 0) && en_out && (absv(m_t) < m_d[k]);
      e_sync <= (m_run != 0) && (m_up != 0) && (m_t == -m_h);
      if (!en_tmr) m_run <= 0;
      else if (m_run == 0) begin
        m_run <= 1; m_h <= half_of(m_ptm); m_d <= m_pd; m_t <= -half_of(m_ptm); m_up <= 1;
      end else if (m_up != 0) begin
        if (m_t == m_h - 1) begin
          m_up <= 0;
          if (m_dbl != 0) begin m_h <= half_of(m_ptm); m_d <= m_pd; m_t <= half_of(m_ptm); end
          else m_t <= m_h;
        end else m_t <= m_t + 1;
      end else begin
        if (m_t == -m_h + 1) begin
          m_up <= 1; m_h <= half_of(m_ptm); m_d <= m_pd; m_t <= -half_of(m_ptm);
        end else m_t <= m_t - 1;
      end
    end
  end

  // Per-cycle comparison and period measurements at the falling edge
  int cyc = 0, sync_cyc = 0, gap_last = 0, nsync = 0;
  int hrun [NCH];
  int hlast [NCH];

  always @(negedge clk) begin
    cyc++;
    if (cmp_on) begin
      vectors++;
      if (pwm_out !== e_out || sync_out !== e_sync) begin
        miscompares++;
        $display("FAIL %s cycle %0d: out=%b sync=%b expected out=%b sync=%b",
                 cur_req, cyc, pwm_out, sync_out, e_out, e_sync);
      end
    end
    if (sync_out === 1'b1) begin
      gap_last = cyc - sync_cyc;
      sync_cyc = cyc;
      nsync++;
      for (int k = 0; k < NCH; k++) begin hlast[k] = hrun[k]; hrun[k] = int'(pwm_out[k]); end
    end else begin
      for (int k = 0; k < NCH; k++) hrun[k] += int'(pwm_out[k]);
    end
  end

  task automatic check(string req, int act, int exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int addr, int data);
    wr_en = 1'b1; wr_addr = AW'(addr); wr_data = W'(data);
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic next_gap(output int g);
    int n0;
    n0 = nsync;
    for (int i = 0; i < 5000 && nsync == n0; i++) begin @(negedge clk); #1; end
    g = gap_last;
  endtask

  task automatic restart();
    en_tmr = 1'b0;
    @(negedge clk); #1;
    en_tmr = 1'b1;
  endtask

  task automatic t_reset();
    int g;
    cur_req = "R1";
    check("R1 pwm_out after reset", int'(pwm_out), 0);
    check("R1 sync after reset", int'(sync_out), 0);
    cmp_on = 1'b1;
    cur_req = "R9";
    repeat (10) @(negedge clk);
    #1;
    check("R9 no sync while stopped", nsync, 0);
    cur_req = "R1";
    en_tmr = 1'b1; en_out = 1'b1;
    next_gap(g); next_gap(g);
    check("R1 default period gap", g, 16);
  endtask

  task automatic t_single();
    int g;
    cur_req = "R3";
    wr(0, 16); wr(1, 3); wr(2, 0); wr(3, 9);
    restart();
    next_gap(g); next_gap(g);
    check("R2 sync gap H=8", g, 32);
    check("R3 chan A high cycles D=3", hlast[0], 10);
    check("R3 chan B high cycles D=0", hlast[1], 0);
    check("R3 chan C high cycles D>H", hlast[2], 32);
    cur_req = "R4";
    wr(1, 5);
    next_gap(g);
    check("R4 old duty kept in current period", hlast[0], 10);
    next_gap(g);
    check("R4 new duty from next period", hlast[0], 18);
  endtask

  task automatic t_period_single();
    int g;
    cur_req = "R6";
    next_gap(g);
    wr(0, 24);
    next_gap(g);
    check("R4 period write leaves current period", g, 32);
    next_gap(g);
    check("R6 new period applies at boundary", g, 48);
    next_gap(g);
    check("R6 new period persists", g, 48);
  endtask

  task automatic t_double();
    int g;
    cur_req = "R5";
    wr(0, 16); wr(1, 3); wr(4, 1);
    restart();
    next_gap(g);
    wr(1, 5);
    next_gap(g);
    check("R5 duty split across legs", hlast[0], 14);
    next_gap(g);
    wr(0, 24);
    next_gap(g);
    check("R5 mid-period period reload", g, 40);
    next_gap(g);
    check("R6 full new period after mid reload", g, 48);
    wr(4, 0);
  endtask

  task automatic t_restart();
    int g;
    cur_req = "R7";
    wr(0, 12);
    repeat (7) @(negedge clk);
    #1;
    restart();
    @(negedge clk); @(negedge clk); #1;
    check("R7 sync two edges after re-enable", int'(sync_out), 1);
    next_gap(g);
    check("R7 period after restart uses pending TM", g, 24);
  endtask

  task automatic t_gate();
    int g;
    int n0;
    cur_req = "R8";
    en_out = 1'b0;
    next_gap(g);
    n0 = nsync;
    next_gap(g);
    check("R8 outputs low while gated", hlast[2], 0);
    check("R8 sync continues while gated", nsync - n0, 1);
    en_out = 1'b1;
  endtask

  task automatic t_clamp();
    int g;
    cur_req = "R10";
    wr(0, 1);
    restart();
    next_gap(g); next_gap(g);
    check("R10 period 1 gives 4-cycle gap", g, 4);
    wr(0, 0);
    restart();
    next_gap(g); next_gap(g);
    check("R10 period 0 gives 4-cycle gap", g, 4);
    cur_req = "R9";
    en_tmr = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R9 outputs low when stopped", int'(pwm_out), 0);
    check("R9 sync low when stopped", int'(sync_out), 0);
  endtask

  bit done = 1'b0;

  initial begin
    for (int k = 0; k < NCH; k++) begin hrun[k] = 0; hlast[k] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    t_reset();
    t_single();
    t_period_single();
    t_double();
    t_restart();
    t_gate();
    t_clamp();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule